// File: doc/BRIEF.md
# Isochronous Receive Interrupt Event Bank

This block keeps one pending-event flag for each of four isochronous receive contexts. Each context drives a level interrupt line. When that line goes from low to high, the flag for that context is captured and held, so a short pulse is not missed. Software sees the flags through a small register window. A write-one-to-set alias raises flags and a write-one-to-clear alias drops them. No other path clears a flag.

A second set/clear pair holds a per-context enable mask. Reading the clear alias of the event pair returns the events already ANDed with that mask, so a handler needs only one read to find the contexts it must service. A registered summary output, the OR of all masked events, feeds one bit of a wider chip-level interrupt register. The read port has one cycle of latency, and the read data is zero in any cycle without a read.

Top module: `iso_rx_evt_bank`

## Requirements
- R1: Event flag for context i lives in read-data bit i (bits 3..0). A read at offset 0xA0 returns the raw flags on `bus_rdata` in the cycle after `bus_rd` is sampled.
- R2: Bits 31..4 of `bus_rdata` are always zero. A read of an offset outside 0xA0, 0xA4, 0xA8, 0xAC returns zero.
- R3: A low-to-high transition of `irq_in[i]` sets event flag i. A line that stays high after its flag was cleared does not set the flag again.
- R4: A write at offset 0xA0 sets every flag whose `bus_wdata` bit is 1. Bits written as 0 leave their flags unchanged.
- R5: A write at offset 0xA4 clears every flag whose `bus_wdata` bit is 1. Bits written as 0 leave their flags unchanged, and this is the only way a flag is cleared.
- R6: A read at offset 0xA4 returns the event flags bitwise ANDed with the mask.
- R7: The mask is set by write-one at offset 0xA8 and cleared by write-one at offset 0xAC. A read at either offset returns the mask, and the mask resets to 0.
- R8: `evt_summary` is a register that, one cycle after the state it reflects, equals the OR over contexts of (event AND mask). It is 0 out of reset.
- R9: If a rising edge on `irq_in[i]` and a clear-alias write of bit i fall in the same cycle, flag i ends up set.
- R10: Reset (synchronous, active high) clears the stored copy of each interrupt line. A line held high through reset therefore records an event in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 4 | Level interrupt line from each receive context |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| evt_summary | output | 1 | Registered OR of masked events |

## Verification
The interrupt lines are driven with isolated single-lane rises, two lanes rising together, and a line held high across a clear. These show the difference between edge capture and level capture. Software writes are sent with mixed one and zero bits, and with all-ones in the unused upper bits. This shows that only bits written as 1 act, and only on the addressed pair. The masked and raw views are read back against mask patterns that overlap the events partly, fully and not at all. Two timing cases are also covered: the same-cycle collision of an edge with a clear, and a line held high across reset.

// File: rtl/iso_evt_pkg.sv
package iso_evt_pkg;

  localparam int unsigned REG_DATA_W = 32;
  localparam int unsigned REG_ADDR_W = 8;

  localparam logic [REG_ADDR_W-1:0] OFS_EVT_SET = 8'hA0;
  localparam logic [REG_ADDR_W-1:0] OFS_EVT_CLR = 8'hA4;
  localparam logic [REG_ADDR_W-1:0] OFS_MSK_SET = 8'hA8;
  localparam logic [REG_ADDR_W-1:0] OFS_MSK_CLR = 8'hAC;

  typedef struct packed {
    logic evt_set;
    logic evt_clr;
    logic msk_set;
    logic msk_clr;
  } wr_strb_t;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_EVT_RAW,
    RD_EVT_MASKED,
    RD_MASK
  } rd_src_e;

endpackage

// File: rtl/iso_edge_det.sv
module iso_edge_det #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lvl,
  output logic [LANES-1:0] rise
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lvl_d;

    always_ff @(posedge clk) begin
      if (rst) lvl_d <= 1'b0;
      else     lvl_d <= lvl[g];
    end

    assign rise[g] = lvl[g] & ~lvl_d;
  end

endmodule

// File: rtl/iso_sc_bank.sv
module iso_sc_bank #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] hw_set,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [LANES-1:0] wbits,
  output logic [LANES-1:0] q
);

  for (genvar g = 0; g < LANES; g++) begin : g_bit
    logic bit_q;
    logic do_set;
    logic do_clr;

    assign do_set = hw_set[g] | (set_en & wbits[g]);
    assign do_clr = clr_en & wbits[g];

    // setting sources take priority over clearing
    always_ff @(posedge clk) begin
      if (rst)         bit_q <= 1'b0;
      else if (do_set) bit_q <= 1'b1;
      else if (do_clr) bit_q <= 1'b0;
    end

    assign q[g] = bit_q;
  end

endmodule

// File: rtl/iso_reg_decode.sv
module iso_reg_decode
  import iso_evt_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned DATA_W = REG_DATA_W,
  parameter int unsigned ADDR_W = REG_ADDR_W,
  parameter logic [ADDR_W-1:0] EVT_SET_OFS = ADDR_W'(OFS_EVT_SET),
  parameter logic [ADDR_W-1:0] EVT_CLR_OFS = ADDR_W'(OFS_EVT_CLR),
  parameter logic [ADDR_W-1:0] MSK_SET_OFS = ADDR_W'(OFS_MSK_SET),
  parameter logic [ADDR_W-1:0] MSK_CLR_OFS = ADDR_W'(OFS_MSK_CLR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [LANES-1:0]  evt,
  input  logic [LANES-1:0]  msk,
  output wr_strb_t          strb,
  output logic [LANES-1:0]  wbits,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned PAD_W = DATA_W - LANES;

  rd_src_e          rd_src;
  logic [LANES-1:0] rd_lanes;
  logic             unused_hi;

  assign wbits     = bus_wdata[LANES-1:0];
  assign unused_hi = ^bus_wdata[DATA_W-1:LANES];

  always_comb begin
    strb   = '0;
    rd_src = RD_NONE;
    if (bus_addr == EVT_SET_OFS) begin
      strb.evt_set = bus_wr;
      rd_src       = RD_EVT_RAW;
    end else if (bus_addr == EVT_CLR_OFS) begin
      strb.evt_clr = bus_wr;
      rd_src       = RD_EVT_MASKED;
    end else if (bus_addr == MSK_SET_OFS) begin
      strb.msk_set = bus_wr;
      rd_src       = RD_MASK;
    end else if (bus_addr == MSK_CLR_OFS) begin
      strb.msk_clr = bus_wr;
      rd_src       = RD_MASK;
    end
  end

  always_comb begin
    case (rd_src)
      RD_EVT_RAW:    rd_lanes = evt;
      RD_EVT_MASKED: rd_lanes = evt & msk;
      RD_MASK:       rd_lanes = msk;
      default:       rd_lanes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (bus_rd) rdata <= {{PAD_W{1'b0}}, rd_lanes};
    else             rdata <= '0;
  end

endmodule

// File: rtl/iso_rx_evt_bank.sv
module iso_rx_evt_bank
  import iso_evt_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned DATA_W = REG_DATA_W,
  parameter int unsigned ADDR_W = REG_ADDR_W,
  parameter logic [ADDR_W-1:0] EVT_SET_OFS = ADDR_W'(OFS_EVT_SET),
  parameter logic [ADDR_W-1:0] EVT_CLR_OFS = ADDR_W'(OFS_EVT_CLR),
  parameter logic [ADDR_W-1:0] MSK_SET_OFS = ADDR_W'(OFS_MSK_SET),
  parameter logic [ADDR_W-1:0] MSK_CLR_OFS = ADDR_W'(OFS_MSK_CLR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  irq_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              evt_summary
);

  wr_strb_t         strb;
  logic [LANES-1:0] wbits;
  logic [LANES-1:0] irq_rise;
  logic [LANES-1:0] evt_q;
  logic [LANES-1:0] msk_q;

  iso_edge_det #(.LANES(LANES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (irq_in),
    .rise (irq_rise)
  );

  iso_reg_decode #(
    .LANES(LANES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .EVT_SET_OFS(EVT_SET_OFS), .EVT_CLR_OFS(EVT_CLR_OFS),
    .MSK_SET_OFS(MSK_SET_OFS), .MSK_CLR_OFS(MSK_CLR_OFS)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt       (evt_q),
    .msk       (msk_q),
    .strb      (strb),
    .wbits     (wbits),
    .rdata     (bus_rdata)
  );

  iso_sc_bank #(.LANES(LANES)) u_evt (
    .clk    (clk),
    .rst    (rst),
    .hw_set (irq_rise),
    .set_en (strb.evt_set),
    .clr_en (strb.evt_clr),
    .wbits  (wbits),
    .q      (evt_q)
  );

  iso_sc_bank #(.LANES(LANES)) u_msk (
    .clk    (clk),
    .rst    (rst),
    .hw_set ('0),
    .set_en (strb.msk_set),
    .clr_en (strb.msk_clr),
    .wbits  (wbits),
    .q      (msk_q)
  );

  always_ff @(posedge clk) begin
    if (rst) evt_summary <= 1'b0;
    else     evt_summary <= |(evt_q & msk_q);
  end

endmodule

// File: rtl/iso_evt_chk.sv
module iso_evt_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] EVT_SET_OFS = 8'hA0,
  parameter logic [ADDR_W-1:0] EVT_CLR_OFS = 8'hA4,
  parameter logic [ADDR_W-1:0] MSK_SET_OFS = 8'hA8,
  parameter logic [ADDR_W-1:0] MSK_CLR_OFS = 8'hAC
) (
  input logic              clk,
  input logic              rst,
  input logic [LANES-1:0]  irq_in,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              evt_summary,
  input logic [LANES-1:0]  evt,
  input logic [LANES-1:0]  msk
);

  logic chk_live;
  logic unused_chk;

  assign unused_chk = ^bus_wdata[DATA_W-1:LANES];

  always_ff @(posedge clk) begin
    if (rst) chk_live <= 1'b0;
    else     chk_live <= 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // R3
    rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
      (chk_live && irq_in[g] && !$past(irq_in[g])) |=> evt[g]);

    // R4
    sw_set_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == EVT_SET_OFS && bus_wdata[g]) |=> evt[g]);

    // R5
    sw_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (chk_live && bus_wr && bus_addr == EVT_CLR_OFS && bus_wdata[g]
       && !(irq_in[g] && !$past(irq_in[g]))) |=> !evt[g]);

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (evt[g] && !(bus_wr && bus_addr == EVT_CLR_OFS && bus_wdata[g])) |=> evt[g]);

    // R9
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (chk_live && irq_in[g] && !$past(irq_in[g])
       && bus_wr && bus_addr == EVT_CLR_OFS && bus_wdata[g]) |=> evt[g]);
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:LANES] == '0);

  // R6
  masked_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == EVT_CLR_OFS)
    |=> bus_rdata[LANES-1:0] == $past(evt & msk));

  // R7
  mask_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == MSK_SET_OFS || bus_addr == MSK_CLR_OFS))
    |=> bus_rdata[LANES-1:0] == $past(msk));

  // R8
  summary_chk: assert property (@(posedge clk) disable iff (rst)
    chk_live |-> evt_summary == $past(|(evt & msk)));

endmodule

bind iso_rx_evt_bank iso_evt_chk #(
  .LANES(LANES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .EVT_SET_OFS(EVT_SET_OFS), .EVT_CLR_OFS(EVT_CLR_OFS),
  .MSK_SET_OFS(MSK_SET_OFS), .MSK_CLR_OFS(MSK_CLR_OFS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_in      (irq_in),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .evt_summary (evt_summary),
  .evt         (evt_q),
  .msk         (msk_q)
);

// File: tb/sim_iso_rx_evt_bank.sv
module sim_iso_rx_evt_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  irq_in = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        evt_summary;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  iso_rx_evt_bank u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_summary(evt_summary)
  );

  // op: 0 idle, 1 write, 2 read ; fields {op, addr, wdata, irq, expected}
  localparam int NV = 24;
  localparam logic [21:0] VEC [NV] = '{
    {2'd1, 8'hA8, 4'h5, 4'h0, 4'h0},
    {2'd2, 8'hA8, 4'h0, 4'h0, 4'h5},
    {2'd2, 8'hAC, 4'h0, 4'h0, 4'h5},
    {2'd2, 8'hA0, 4'h0, 4'h0, 4'h0},
    {2'd0, 8'h00, 4'h0, 4'h1, 4'h0},
    {2'd2, 8'hA0, 4'h0, 4'h1, 4'h1},
    {2'd1, 8'hA4, 4'h1, 4'h1, 4'h0},
    {2'd2, 8'hA0, 4'h0, 4'h1, 4'h0},
    {2'd0, 8'h00, 4'h0, 4'h0, 4'h0},
    {2'd0, 8'h00, 4'h0, 4'hA, 4'h0},
    {2'd2, 8'hA0, 4'h0, 4'hA, 4'hA},
    {2'd2, 8'hA4, 4'h0, 4'hA, 4'h0},
    {2'd1, 8'hA0, 4'h1, 4'hA, 4'h0},
    {2'd2, 8'hA4, 4'h0, 4'hA, 4'h1},
    {2'd1, 8'hA0, 4'h0, 4'hA, 4'h0},
    {2'd2, 8'hA0, 4'h0, 4'hA, 4'hB},
    {2'd1, 8'hA4, 4'h0, 4'hA, 4'h0},
    {2'd2, 8'hA0, 4'h0, 4'hA, 4'hB},
    {2'd1, 8'hAC, 4'h1, 4'hA, 4'h0},
    {2'd2, 8'hA4, 4'h0, 4'hA, 4'h0},
    {2'd2, 8'hAC, 4'h0, 4'hA, 4'h4},
    {2'd2, 8'h9C, 4'h0, 4'hA, 4'h0},
    {2'd1, 8'hA4, 4'hF, 4'hA, 4'h0},
    {2'd2, 8'hA0, 4'h0, 4'hA, 4'h0}
  };

  function automatic string vtag(int i);
    case (i)
      1, 2, 20:  return "R7";
      3, 10, 23: return "R1";
      5, 7:      return "R3";
      11, 13, 19: return "R6";
      15:        return "R4";
      17:        return "R5";
      21:        return "R2";
      default:   return "R1";
    endcase
  endfunction

  task automatic cyc(input logic [1:0] op, input logic [7:0] a,
                     input logic [31:0] w, input logic [3:0] irq);
    irq_in    = irq;
    bus_wr    = (op == 2'd1);
    bus_rd    = (op == 2'd2);
    bus_addr  = a;
    bus_wdata = w;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // reset with lane 2 held high
    rst = 1'b1;
    cyc(2'd0, 8'h00, 32'h0, 4'h4);
    cyc(2'd0, 8'h00, 32'h0, 4'h4);
    cyc(2'd0, 8'h00, 32'h0, 4'h4);
    chk("R10 summary in reset", {31'b0, evt_summary}, 32'h0);
    chk("R2 rdata in reset", bus_rdata, 32'h0);
    rst = 1'b0;
    cyc(2'd0, 8'h00, 32'h0, 4'h4);
    cyc(2'd2, 8'hA0, 32'h0, 4'h4);
    chk("R10 level held over reset", bus_rdata & 32'h4, 32'h4);
    cyc(2'd2, 8'hA8, 32'h0, 4'h4);
    chk("R7 mask reset", bus_rdata, 32'h0);
    cyc(2'd1, 8'hA4, 32'hF, 4'h0);
    cyc(2'd2, 8'hA0, 32'h0, 4'h0);
    chk("R5 clear all", bus_rdata, 32'h0);

    // table
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][21:20], VEC[i][19:12],
          (VEC[i][21:20] == 2'd1) ? {28'hFFFFFFF, VEC[i][11:8]} : 32'h0,
          VEC[i][7:4]);
      if (VEC[i][21:20] == 2'd2)
        chk($sformatf("%s vector %0d", vtag(i), i), bus_rdata, {28'h0, VEC[i][3:0]});
    end

    // summary latency: mask 0101, events 0
    cyc(2'd1, 8'hA8, 32'h1, 4'h0);
    cyc(2'd1, 8'hA0, 32'h1, 4'h0);
    chk("R8 summary lags event", {31'b0, evt_summary}, 32'h0);
    cyc(2'd0, 8'h00, 32'h0, 4'h0);
    chk("R8 summary asserted", {31'b0, evt_summary}, 32'h1);
    cyc(2'd1, 8'hAC, 32'h1, 4'h0);
    chk("R8 summary lags mask clear", {31'b0, evt_summary}, 32'h1);
    cyc(2'd0, 8'h00, 32'h0, 4'h0);
    chk("R8 summary dropped", {31'b0, evt_summary}, 32'h0);

    // edge vs clear collision
    cyc(2'd1, 8'hA4, 32'hF, 4'h0);
    cyc(2'd1, 8'hA4, 32'h2, 4'h2);
    cyc(2'd2, 8'hA0, 32'h0, 4'h2);
    chk("R9 edge beats clear", bus_rdata, 32'h2);

    // reserved bits and masked view with all events
    cyc(2'd1, 8'hA0, 32'hFFFFFFFF, 4'h0);
    cyc(2'd2, 8'hA0, 32'h0, 4'h0);
    chk("R2 upper bits zero", bus_rdata, 32'hF);
    cyc(2'd2, 8'hA4, 32'h0, 4'h0);
    chk("R6 masked all set", bus_rdata, 32'h4);
    cyc(2'd2, 8'hB0, 32'h0, 4'h0);
    chk("R2 unmapped offset", bus_rdata, 32'h0);
    cyc(2'd0, 8'h00, 32'h0, 4'h0);
    chk("R2 no read gives zero", bus_rdata, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule